// File: doc/BRIEF.md
# Shared Packed Booth Multiplier

This block is a two-stage pipelined multiplier. One radix-4 Booth array per 32-bit lane serves two kinds of work. In the integer formats, each lane holds two signed 16-bit elements, and the array forms both element products side by side. The partial-product rows that would create the cross terms are cleared, and carries are kept from crossing the seam between the two 32-bit product fields. In the float format, the array multiplies the two 24-bit significands of a lane, with the hidden bit restored, and returns the normalised upper 24 bits of the product and a flag that marks where the leading one landed.

A new operation may be issued on every clock. The first stage encodes the multiplier, selects the Booth rows and compresses sixteen of the seventeen rows with 4:2 compressors. The second stage finishes the carry-save reduction, runs the carry-propagate add for both 32-bit halves and picks the per-lane result. Sign, exponent and rounding of the float format are left to surrounding logic.

Top module: `pmul_shared`

## Requirements
- R1: A request accepted with `in_valid` high at a rising edge appears with `out_valid` high exactly two rising edges later. Requests issued on consecutive cycles produce results on consecutive cycles.
- R2: With `in_mode` = 0 (low half), lane k returns {low 16 bits of AH*BH, low 16 bits of AL*BL}. The products are signed. AL/BL are bits [32k+15:32k] of `a`/`b`, and AH/BH are bits [32k+31:32k+16].
- R3: With `in_mode` = 1 (high half), lane k returns {bits 31:16 of AH*BH, bits 31:16 of AL*BL} for the signed products.
- R4: With `in_mode` = 2 (rounded high half), each 16-bit field is bits 31:16 of (signed product + 0x8000), taken modulo 2^32.
- R5: In the integer modes, the two element products of a lane do not disturb each other, including extreme operands such as 0x8000 x 0x8000, 0xFFFF x 0xFFFF and zero in the neighbouring element.
- R6: With `in_mode` = 3 (float), lane k multiplies {1, a[32k+22:32k]} by {1, b[32k+22:32k]} to form a 48-bit product P. The flag is P[47]. The lane result is {8'h00, P[47:24]} when the flag is 1, and {8'h00, P[46:23]} otherwise. Bits 31:23 of each input lane have no effect.
- R7: `norm_flag` is zero for every lane of an integer-mode result.
- R8: While `out_valid` is low, `res` and `norm_flag` are zero.
- R9: While `rst_n` is low, `out_valid`, `res` and `norm_flag` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe, one operation per cycle |
| in_mode | input | 2 | 0 low half, 1 high half, 2 rounded high half, 3 float significand |
| a | input | 64 | Multiplicand, two 32-bit lanes |
| b | input | 64 | Multiplier, two 32-bit lanes |
| out_valid | output | 1 | Result strobe, two cycles after the request |
| res | output | 64 | Two 32-bit lane results |
| norm_flag | output | 2 | Per-lane float leading-one flag |

## Verification
The bench builds the block with its default of two lanes and sixteen-bit elements. At that size one run covers both product fields of both lanes, so a fault at the field seam or a carry leaking between lanes shows in the compared 64-bit result. Requests stream every cycle with random gaps, so the reference pipeline exposes any slip in the two-cycle latency. Directed operands at the signed extremes and at significand all-ones and all-zeros hit the Booth rows that carry the most negative multiples and the float flag in both states.

// File: rtl/pmul_pkg.sv
package pmul_pkg;
  localparam int EW   = 16;                 // integer element width
  localparam int LW   = 2 * EW;             // lane width
  localparam int SIGW = 24;                 // float significand width incl. hidden bit
  localparam int AW   = 2 * LW;             // array row width
  localparam int NPP  = LW / 2 + 1;         // Booth rows per lane
  localparam int NGRP = (NPP - 1) / 4;      // 4:2 groups in stage one
  localparam int NV   = 2 * NGRP + 1;       // vectors registered between stages

  typedef enum logic [1:0] {
    MODE_LO = 2'd0,
    MODE_HI = 2'd1,
    MODE_HR = 2'd2,
    MODE_FP = 2'd3
  } mul_mode_e;

  typedef struct packed {
    logic neg;
    logic one;
    logic two;
  } booth_dig_t;

  typedef struct packed {
    logic [AW-1:0] s;
    logic [AW-1:0] c;
  } cs_pair_t;

  // radix-4 digit from {y[2j+1], y[2j], y[2j-1]}
  function automatic booth_dig_t booth_enc(input logic [2:0] grp);
    booth_dig_t d;
    d = '0;
    case (grp)
      3'b001, 3'b010: d.one = 1'b1;
      3'b011:         d.two = 1'b1;
      3'b100:         begin d.neg = 1'b1; d.two = 1'b1; end
      3'b101, 3'b110: begin d.neg = 1'b1; d.one = 1'b1; end
      default:        d = '0;
    endcase
    return d;
  endfunction

  // full-adder row; cut drops the carry entering the upper product field
  function automatic cs_pair_t csa3(input logic [AW-1:0] x, input logic [AW-1:0] y,
                                    input logic [AW-1:0] z, input logic cut);
    cs_pair_t r;
    logic [AW-1:0] maj;
    r.s = x ^ y ^ z;
    maj = (x & y) | (x & z) | (y & z);
    r.c = {maj[AW-2:0], 1'b0};
    if (cut) r.c[LW] = 1'b0;
    return r;
  endfunction

  function automatic cs_pair_t csa4(input logic [AW-1:0] w, input logic [AW-1:0] x,
                                    input logic [AW-1:0] y, input logic [AW-1:0] z,
                                    input logic cut);
    cs_pair_t t;
    t = csa3(w, x, y, cut);
    return csa3(t.s, t.c, z, cut);
  endfunction

  // pick 16 bits out of one 32-bit element product
  function automatic logic [EW-1:0] int_pick(input logic [LW-1:0] p, input mul_mode_e m);
    logic [LW-1:0] t;
    t = p + {{(LW-EW){1'b0}}, 1'b1, {(EW-1){1'b0}}};
    case (m)
      MODE_HI: return p[LW-1:EW];
      MODE_HR: return t[LW-1:EW];
      default: return p[EW-1:0];
    endcase
  endfunction

  // {flag, normalised top significand bits}
  function automatic logic [SIGW:0] fp_norm(input logic [2*SIGW-1:0] p);
    if (p[2*SIGW-1]) return {1'b1, p[2*SIGW-1:SIGW]};
    return {1'b0, p[2*SIGW-2:SIGW-1]};
  endfunction
endpackage

// File: rtl/booth_row.sv
module booth_row
  import pmul_pkg::*;
#(
  parameter int J = 0
) (
  input  logic [2:0]    grp,
  input  logic [AW-1:0] mc,
  input  logic          mask_hi,
  output logic [AW-1:0] pp
);
  booth_dig_t    d;
  logic [AW-1:0] mag;
  logic [AW-1:0] sh;

  assign d = booth_enc(grp);

  always_comb begin
    mag = d.two ? {mc[AW-2:0], 1'b0} : (d.one ? mc : '0);
    sh  = (d.neg ? (~mag + AW'(1)) : mag) << (2 * J);
    pp  = mask_hi ? {{(AW-LW){1'b0}}, sh[LW-1:0]} : sh;
  end
endmodule

// File: rtl/booth_pp_gen.sv
module booth_pp_gen
  import pmul_pkg::*;
(
  input  logic                    fp,
  input  logic [LW-1:0]           a_l,
  input  logic [LW-1:0]           b_l,
  output logic [NPP-1:0][AW-1:0]  pp
);
  localparam int YW = 2 * NPP;

  logic [YW-1:0] y;
  logic [YW:0]   yx;
  logic [AW-1:0] mc_lo;
  logic [AW-1:0] mc_hi;
  logic [AW-1:0] mc_fp;

  assign y     = fp ? {{(YW-SIGW){1'b0}}, 1'b1, b_l[SIGW-2:0]} : {{(YW-LW){1'b0}}, b_l};
  assign yx    = {y, 1'b0};
  assign mc_lo = {{(AW-EW){a_l[EW-1]}}, a_l[EW-1:0]};
  assign mc_hi = {{(AW-LW){a_l[LW-1]}}, a_l[LW-1:EW], {EW{1'b0}}};
  assign mc_fp = {{(AW-SIGW){1'b0}}, 1'b1, a_l[SIGW-2:0]};

  for (genvar j = 0; j < NPP; j++) begin : g_row
    logic [2:0]    grp;
    logic [AW-1:0] mc;
    if (j == EW / 2) begin : g_seam
      // the upper element starts fresh: no borrow from the lower element's sign
      assign grp = {yx[2*j+2], yx[2*j+1], yx[2*j] & fp};
    end else if (j == NPP - 1) begin : g_top
      assign grp = yx[2*j+2:2*j] & {3{fp}};
    end else begin : g_mid
      assign grp = yx[2*j+2:2*j];
    end
    if (j < EW / 2) begin : g_mlo
      assign mc = fp ? mc_fp : mc_lo;
    end else begin : g_mhi
      assign mc = fp ? mc_fp : mc_hi;
    end
    booth_row #(.J(j)) u_row (
      .grp     (grp),
      .mc      (mc),
      .mask_hi (!fp && (j < EW / 2)),
      .pp      (pp[j])
    );
  end
endmodule

// File: rtl/csa_front.sv
module csa_front
  import pmul_pkg::*;
(
  input  logic                   cut,
  input  logic [NPP-1:0][AW-1:0] pp,
  output logic [NV-1:0][AW-1:0]  v
);
  for (genvar g = 0; g < NGRP; g++) begin : g_c42
    cs_pair_t r;
    assign r        = csa4(pp[4*g], pp[4*g+1], pp[4*g+2], pp[4*g+3], cut);
    assign v[2*g]   = r.s;
    assign v[2*g+1] = r.c;
  end
  assign v[NV-1] = pp[NPP-1];
endmodule

// File: rtl/csa_back.sv
module csa_back
  import pmul_pkg::*;
(
  input  mul_mode_e              mode,
  input  logic [NV-1:0][AW-1:0]  v,
  output logic [LW-1:0]          lane_res,
  output logic                   nflag
);
  cs_pair_t          a0, a1, a2, b0, b1, f;
  logic              cut;
  logic [LW:0]       lo;
  logic [LW-1:0]     hi;
  logic [2*SIGW-1:0] fprod;
  logic [SIGW:0]     fn;

  always_comb begin
    cut   = (mode != MODE_FP);
    a0    = csa3(v[0], v[1], v[2], cut);
    a1    = csa3(v[3], v[4], v[5], cut);
    a2    = csa3(v[6], v[7], v[8], cut);
    b0    = csa3(a0.s, a0.c, a1.s, cut);
    b1    = csa3(a1.c, a2.s, a2.c, cut);
    f     = csa4(b0.s, b0.c, b1.s, b1.c, cut);
    lo    = {1'b0, f.s[LW-1:0]} + {1'b0, f.c[LW-1:0]};
    hi    = f.s[AW-1:LW] + f.c[AW-1:LW] + (cut ? '0 : {{(LW-1){1'b0}}, lo[LW]});
    fprod = {hi[2*SIGW-LW-1:0], lo[LW-1:0]};
    fn    = fp_norm(fprod);
    if (cut) begin
      lane_res = {int_pick(hi, mode), int_pick(lo[LW-1:0], mode)};
      nflag    = 1'b0;
    end else begin
      lane_res = {{(LW-SIGW){1'b0}}, fn[SIGW-1:0]};
      nflag    = fn[SIGW];
    end
  end
endmodule

// File: rtl/pmul_shared.sv
module pmul_shared
  import pmul_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [1:0]            in_mode,
  input  logic [LANES*LW-1:0]   a,
  input  logic [LANES*LW-1:0]   b,
  output logic                  out_valid,
  output logic [LANES*LW-1:0]   res,
  output logic [LANES-1:0]      norm_flag
);
  mul_mode_e                          in_m;
  mul_mode_e                          s1_mode;
  mul_mode_e                          o_mode;
  logic                               s1_valid;
  logic [LANES-1:0][NV-1:0][AW-1:0]   v_w;
  logic [LANES-1:0][NV-1:0][AW-1:0]   s1_vec;
  logic [LANES-1:0][LW-1:0]           lane_res_w;
  logic [LANES-1:0]                   nflag_w;

  assign in_m = mul_mode_e'(in_mode);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [NPP-1:0][AW-1:0] pp;
    booth_pp_gen u_gen (
      .fp  (in_m == MODE_FP),
      .a_l (a[l*LW +: LW]),
      .b_l (b[l*LW +: LW]),
      .pp  (pp)
    );
    csa_front u_front (
      .cut (in_m != MODE_FP),
      .pp  (pp),
      .v   (v_w[l])
    );
    csa_back u_back (
      .mode     (s1_mode),
      .v        (s1_vec[l]),
      .lane_res (lane_res_w[l]),
      .nflag    (nflag_w[l])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      s1_mode   <= MODE_LO;
      s1_vec    <= '0;
      out_valid <= 1'b0;
      o_mode    <= MODE_LO;
      res       <= '0;
      norm_flag <= '0;
    end else begin
      s1_valid  <= in_valid;
      s1_mode   <= in_m;
      s1_vec    <= v_w;
      out_valid <= s1_valid;
      o_mode    <= s1_mode;
      res       <= s1_valid ? lane_res_w : '0;
      norm_flag <= s1_valid ? nflag_w : '0;
    end
  end
endmodule

// File: rtl/pmul_shared_chk.sv
module pmul_shared_chk
  import pmul_pkg::*;
#(
  parameter int LANES = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                out_valid,
  input logic [LANES*LW-1:0] res,
  input logic [LANES-1:0]    norm_flag,
  input mul_mode_e           o_mode
);
  logic [1:0] warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm <= '0;
    else if (warm != 2'd2) warm <= warm + 2'd1;
  end

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd2) |-> (out_valid == $past(in_valid, 2))); // R1

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (res == '0 && norm_flag == '0)); // R8

  AST_NORM_INT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && o_mode != MODE_FP) |-> (norm_flag == '0)); // R7

  for (genvar l = 0; l < LANES; l++) begin : g_fp
    AST_FP_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && o_mode == MODE_FP) |->
        (res[l*LW + SIGW - 1] && res[l*LW + LW - 1 -: LW - SIGW] == '0)); // R6
  end
endmodule

bind pmul_shared pmul_shared_chk #(.LANES(LANES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .res       (res),
  .norm_flag (norm_flag),
  .o_mode    (o_mode)
);

// File: tb/tb_pmul_shared.sv
module tb_pmul_shared;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  in_mode = 2'd0;
  logic [63:0] a = '0;
  logic [63:0] b = '0;
  logic        out_valid;
  logic [63:0] res;
  logic [1:0]  norm_flag;

  always #10 clk = ~clk;

  pmul_shared dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
    .a(a), .b(b), .out_valid(out_valid), .res(res), .norm_flag(norm_flag)
  );

  int checks = 0;
  int fails = 0;
  logic        p1_v = 1'b0, p2_v = 1'b0;
  logic [63:0] p1_r = '0, p2_r = '0;
  logic [1:0]  p1_n = '0, p2_n = '0;
  string       p1_t = "", p2_t = "";

  function automatic logic [32:0] ref_lane(input logic [1:0] m, input logic [31:0] x,
                                           input logic [31:0] y);
    logic signed [31:0] pl, ph;
    logic [31:0] tl, th, r;
    logic [47:0] fp;
    logic flag;
    pl = $signed(x[15:0]) * $signed(y[15:0]);
    ph = $signed(x[31:16]) * $signed(y[31:16]);
    tl = pl + 32'h8000;
    th = ph + 32'h8000;
    fp = {24'd0, 1'b1, x[22:0]} * {24'd0, 1'b1, y[22:0]};
    flag = 1'b0;
    case (m)
      2'd0: r = {ph[15:0], pl[15:0]};
      2'd1: r = {ph[31:16], pl[31:16]};
      2'd2: r = {th[31:16], tl[31:16]};
      default: begin
        flag = fp[47];
        r = {8'd0, flag ? fp[47:24] : fp[46:23]};
      end
    endcase
    return {flag, r};
  endfunction

  function automatic string mode_tag(input logic [1:0] m);
    case (m)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a falling edge: check the request issued two steps ago, then drive the next
  task automatic step(input logic v, input logic [1:0] m, input logic [63:0] x,
                      input logic [63:0] y, input string tag);
    logic [32:0] l0, l1;
    if (p2_v) begin
      chk("R1 valid", {63'd0, out_valid}, 64'd1);
      chk(p2_t, res, p2_r);
      chk(p2_t == "R6" ? "R6 flag" : "R7", {62'd0, norm_flag}, {62'd0, p2_n});
    end else begin
      chk("R1 idle", {63'd0, out_valid}, 64'd0);
      chk("R8", {62'd0, norm_flag} | res, 64'd0);
    end
    p2_v = p1_v; p2_r = p1_r; p2_n = p1_n; p2_t = p1_t;
    l0 = ref_lane(m, x[31:0], y[31:0]);
    l1 = ref_lane(m, x[63:32], y[63:32]);
    p1_v = v;
    p1_r = {l1[31:0], l0[31:0]};
    p1_n = {l1[32], l0[32]};
    p1_t = (tag == "") ? mode_tag(m) : tag;
    in_valid = v; in_mode = m; a = x; b = y;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset", {63'd0, out_valid} | res | {62'd0, norm_flag}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // extremes in every integer mode, back to back (R1, R2, R3, R4)
    for (int m = 0; m < 3; m++) begin
      step(1'b1, 2'(m), 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000, "");
      step(1'b1, 2'(m), 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, "");
      step(1'b1, 2'(m), 64'h7FFF_8000_0000_7FFF, 64'h8000_7FFF_1234_0000, "");
      step(1'b1, 2'(m), 64'h0000_0000_0000_0000, 64'hFFFF_8000_7FFF_0001, "");
    end
    // field independence: extreme in one element, zero or small in the other (R5)
    step(1'b1, 2'd0, 64'h0000_8000_8000_0000, 64'h0001_8000_8000_FFFF, "R5");
    step(1'b1, 2'd1, 64'h8000_0000_FFFF_8000, 64'h8000_0000_FFFF_8000, "R5");
    step(1'b1, 2'd2, 64'h0001_FFFF_8000_0001, 64'hFFFF_FFFF_8000_FFFF, "R5");
    step(1'b1, 2'd1, 64'h7FFF_FFFF_FFFF_7FFF, 64'h7FFF_0001_0001_7FFF, "R5");
    // float: flag both ways, upper input bits must not matter (R6)
    step(1'b1, 2'd3, 64'h3F80_0000_FF80_0000, 64'h0000_0000_BF80_0000, "R6");
    step(1'b1, 2'd3, 64'h007F_FFFF_FFFF_FFFF, 64'hC07F_FFFF_7FFF_FFFF, "R6");
    step(1'b1, 2'd3, 64'h0040_0000_0000_0001, 64'h0000_0001_0040_0000, "R6");
    step(1'b0, 2'd0, '0, '0, "");
    step(1'b0, 2'd0, '0, '0, "");
    // random stream with gaps and mode changes every cycle (R1, R2, R3, R4, R6)
    for (int i = 0; i < 600; i++) begin
      logic v;
      v = ($urandom_range(0, 4) != 0);
      step(v, 2'($urandom_range(0, 3)), {$urandom, $urandom}, {$urandom, $urandom}, "");
    end
    repeat (3) step(1'b0, 2'd0, '0, '0, "");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule